// File: doc/BRIEF.md
# Stepped Sawtooth Tone Channel

This block is one voice of a sound generator that makes a coarse sawtooth ramp. A programmable period divider runs on a CPU clock-enable pulse. Every second time the divider expires, an 8-bit accumulator takes a step. On six of those steps it adds a 6-bit rate value. On the seventh it returns to zero. One full waveform therefore lasts fourteen divider periods, and the tone frequency is the CPU clock divided by (period+1)·14. The output level is the top five bits of the accumulator.

Software sets the channel through three byte-wide registers: the rate, the low period byte, and a control byte that holds the high period bits and the channel enable. A 2-bit select picks which register a write goes to. Address decoding, mixing and conversion to analog belong to the surrounding logic. The period and rate should be set while the channel is disabled. Setting the enable bit then starts a clean waveform.

Top module: `saw_tone_channel`

## Requirements
- R1: A write with `wr_sel`=0 stores `wr_data[5:0]` as the rate. `wr_sel`=1 stores `wr_data` as period bits 7:0. `wr_sel`=2 stores `wr_data[3:0]` as period bits 11:8 and `wr_data[7]` as the enable. A write with `wr_sel`=3 changes nothing.
- R2: While enabled, the divider expires once every period+1 cycles in which `tick` is high. Cycles with `tick` low do not advance it.
- R3: A step counter runs 0,1,…,13,0 and advances by one on each divider expiry.
- R4: An expiry that moves the counter to an odd step leaves the accumulator unchanged.
- R5: An expiry that moves the counter to an even step from 2 to 12 adds the rate to the accumulator modulo 256, with no saturation.
- R6: An expiry that moves the counter from 13 back to 0 clears the accumulator. One waveform spans (period+1)·14 ticks.
- R7: `level` equals the accumulator shifted right by 3 while enabled, and is 0 while disabled.
- R8: While the enable is clear, the accumulator and step counter are held at 0 and the divider is held loaded with the period. After the enable is set, the first expiry comes on the period+1-th tick.
- R9: After reset all registers are 0 and `level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | CPU clock-enable pulse that advances the divider |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 rate, 1 period low, 2 period high and enable, 3 unused) |
| wr_data | input | 8 | Write data |
| level | output | 5 | Channel output level |

## Verification
An error in the divider or the step counter first shows up as a `level` change on the wrong tick. The ramp values come from the accumulator, so that change appears at the next acting expiry, which is at most two divider periods later. A wrong accumulator value stays wrong until the seventh acting step clears it, so it shows on `level` for up to a whole waveform. This makes the first step after each clear and the wrapped sums the places where an error first becomes visible. A channel that fails to clear when disabled shows a nonzero level at once, or a ramp that restarts out of phase with the first expiry after enable.

// File: rtl/saw_pkg.sv
package saw_pkg;
  localparam int SAW_RATE_W = 6;
  localparam int SAW_PER_W  = 12;
  localparam int SAW_ACC_W  = 8;
  localparam int SAW_OUT_W  = 5;
  localparam int SAW_STEPS  = 14;

  typedef enum logic [1:0] {
    SEL_RATE  = 2'd0,
    SEL_PLO   = 2'd1,
    SEL_PHI   = 2'd2,
    SEL_SPARE = 2'd3
  } saw_sel_e;
endpackage

// File: rtl/saw_regs.sv
module saw_regs
  import saw_pkg::*;
#(
  parameter int RATE_W = SAW_RATE_W,
  parameter int PER_W  = SAW_PER_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  output logic [RATE_W-1:0] rate,
  output logic [PER_W-1:0]  period,
  output logic              enable
);
  localparam int HI_W = PER_W - 8;

  logic [7:0]      per_lo;
  logic [HI_W-1:0] per_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate   <= '0;
      per_lo <= '0;
      per_hi <= '0;
      enable <= 1'b0;
    end else if (wr_en) begin
      case (saw_sel_e'(wr_sel))
        SEL_RATE: rate   <= wr_data[RATE_W-1:0];
        SEL_PLO:  per_lo <= wr_data;
        SEL_PHI: begin
          per_hi <= wr_data[HI_W-1:0];
          enable <= wr_data[7];
        end
        default: ;
      endcase
    end
  end

  assign period = {per_hi, per_lo};
endmodule

// File: rtl/saw_divider.sv
module saw_divider #(
  parameter int PER_W = saw_pkg::SAW_PER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  output logic             expire
);
  logic [PER_W-1:0] cnt;

  function automatic logic [PER_W-1:0] count_next(input logic [PER_W-1:0] c,
                                                  input logic [PER_W-1:0] p);
    return (c == '0) ? p : c - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!enable) cnt <= period;
    else if (tick)    cnt <= count_next(cnt, period);
  end

  assign expire = enable && tick && (cnt == '0);
endmodule

// File: rtl/saw_ramp.sv
module saw_ramp #(
  parameter int RATE_W = saw_pkg::SAW_RATE_W,
  parameter int ACC_W  = saw_pkg::SAW_ACC_W,
  parameter int STEPS  = saw_pkg::SAW_STEPS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     expire,
  input  logic [RATE_W-1:0]        rate,
  output logic [$clog2(STEPS)-1:0] step,
  output logic [ACC_W-1:0]         acc
);
  localparam int STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  function automatic logic [STEP_W-1:0] step_next(input logic [STEP_W-1:0] s);
    return (s == LAST) ? '0 : s + 1'b1;
  endfunction

  function automatic logic [ACC_W-1:0] acc_next(input logic [STEP_W-1:0] ns,
                                                input logic [ACC_W-1:0]  a,
                                                input logic [RATE_W-1:0] r);
    if (ns == '0)       return '0;
    else if (ns[0])     return a;
    else                return a + ACC_W'(r);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
      acc  <= '0;
    end else if (!enable) begin
      step <= '0;
      acc  <= '0;
    end else if (expire) begin
      step <= step_next(step);
      acc  <= acc_next(step_next(step), acc, rate);
    end
  end
endmodule

// File: rtl/saw_tone_channel.sv
module saw_tone_channel
  import saw_pkg::*;
#(
  parameter int RATE_W = SAW_RATE_W,
  parameter int PER_W  = SAW_PER_W,
  parameter int ACC_W  = SAW_ACC_W,
  parameter int OUT_W  = SAW_OUT_W,
  parameter int STEPS  = SAW_STEPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  output logic [OUT_W-1:0] level
);
  localparam int STEP_W = $clog2(STEPS);

  logic [RATE_W-1:0] cfg_rate;
  logic [PER_W-1:0]  cfg_period;
  logic              cfg_en;
  logic              div_expire;
  logic [STEP_W-1:0] ramp_step;
  logic [ACC_W-1:0]  ramp_acc;

  function automatic logic [OUT_W-1:0] level_of(input logic en, input logic [ACC_W-1:0] a);
    return en ? a[ACC_W-1 -: OUT_W] : '0;
  endfunction

  saw_regs #(.RATE_W(RATE_W), .PER_W(PER_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rate(cfg_rate), .period(cfg_period), .enable(cfg_en)
  );

  saw_divider #(.PER_W(PER_W)) u_div (
    .clk(clk), .rst_n(rst_n), .enable(cfg_en), .tick(tick),
    .period(cfg_period), .expire(div_expire)
  );

  saw_ramp #(.RATE_W(RATE_W), .ACC_W(ACC_W), .STEPS(STEPS)) u_ramp (
    .clk(clk), .rst_n(rst_n), .enable(cfg_en), .expire(div_expire),
    .rate(cfg_rate), .step(ramp_step), .acc(ramp_acc)
  );

  assign level = level_of(cfg_en, ramp_acc);
endmodule

module saw_tone_chk #(
  parameter int RATE_W = 6,
  parameter int ACC_W  = 8,
  parameter int OUT_W  = 5,
  parameter int STEP_W = 4,
  parameter int STEPS  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              cfg_en,
  input logic              div_expire,
  input logic [RATE_W-1:0] cfg_rate,
  input logic [STEP_W-1:0] ramp_step,
  input logic [ACC_W-1:0]  ramp_acc,
  input logic [OUT_W-1:0]  level
);
  p_step_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_step <= STEP_W'(STEPS - 1));

  p_expire_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_expire |-> (tick && cfg_en));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !div_expire) |=> $stable(ramp_acc) && $stable(ramp_step));

  p_odd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && div_expire && !ramp_step[0]) |=> $stable(ramp_acc));

  p_add_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && div_expire && ramp_step[0] && ramp_step != STEP_W'(STEPS - 1))
      |=> ramp_acc == $past(ramp_acc) + ACC_W'($past(cfg_rate)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && div_expire && ramp_step == STEP_W'(STEPS - 1))
      |=> (ramp_acc == '0 && ramp_step == '0));

  p_disabled_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (ramp_acc == '0 && ramp_step == '0));

  p_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> level == '0);
endmodule

bind saw_tone_channel saw_tone_chk #(
  .RATE_W(RATE_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .STEP_W(STEP_W), .STEPS(STEPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_en(cfg_en), .div_expire(div_expire),
  .cfg_rate(cfg_rate), .ramp_step(ramp_step), .ramp_acc(ramp_acc), .level(level)
);

// File: tb/sim_saw_tone_channel.sv
module sim_saw_tone_channel;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    lvl;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [4:0] level;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;
  exp_t sb[$];

  // reference model state
  int m_rate = 0, m_per = 0, m_k = 0;
  bit m_en = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  saw_tone_channel u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .level(level)
  );

  // closed form: expiries so far, step within the 14-step cycle, half-step count of adds
  function automatic int model_level();
    int e, s;
    if (!m_en) return 0;
    e = m_k / (m_per + 1);
    s = e % 14;
    return ((m_rate * (s / 2)) % 256) / 8;
  endfunction

  task automatic cyc(input bit t, input bit w, input int sel, input int d, input string tag);
    exp_t x;
    @(negedge clk);
    tick = t; wr_en = w; wr_sel = 2'(sel); wr_data = 8'(d);
    @(posedge clk);
    #1;
    if (w) begin
      case (sel)
        0: m_rate = d % 64;
        1: m_per = (m_per & 32'hF00) | (d & 8'hFF);
        2: begin
          m_per = (m_per & 32'h0FF) | ((d & 4'hF) << 8);
          if (d[7] && !m_en) m_k = 0;
          m_en = d[7];
        end
        default: ;
      endcase
    end
    if (t && m_en) m_k++;
    x.lvl = model_level();
    x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic setup(input int rate, input int per, input string tag);
    cyc(0, 1, 2, (per >> 8) & 15, tag);
    cyc(0, 1, 0, rate, tag);
    cyc(0, 1, 1, per & 255, tag);
    cyc(0, 1, 2, 128 | ((per >> 8) & 15), tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, tag);
  endtask

  // monitor: pops at the falling edge, away from the push at posedge+1
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      n_vec++;
      if (int'(level) != x.lvl) begin
        n_bad++;
        $display("FAIL %s: level=%0d expected=%0d at %0t", x.tag, level, x.lvl, $time);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (level !== 5'd0) begin
      n_bad++;
      $display("FAIL R9: reset level=%0d expected=0", level);
    end
    rst_n = 1'b1;
    run(5, "R9 ticks while idle after reset");

    // R1 R3 R4 R5 R6 R7: rate 0x0B, period 2, three full waveforms
    setup(8'h0B, 2, "R1 config");
    run(3 * 14 * 3, "R5 R6 ramp rate 0x0B");

    // R8: disable mid-ramp, then restart from step 0
    cyc(0, 1, 2, 8'h00, "R8 disable clears");
    run(10, "R8 disabled ticks");
    setup(8'h2A, 4, "R8 re-enable");
    run(5 * 14 * 2, "R6 max rate without wrap");

    // R5 wrap: 6*63 exceeds 255
    cyc(0, 1, 2, 8'h00, "R8 disable");
    setup(8'h3F, 1, "R1 config wrap");
    run(2 * 14 * 2, "R5 wrap rate 0x3F");

    // R2: period 0 expires on every tick, with gaps of idle cycles
    cyc(0, 1, 2, 8'h00, "R8 disable");
    setup(8'h15, 0, "R1 config period 0");
    for (int i = 0; i < 40; i++) begin
      cyc(1, 0, 0, 0, "R2 tick");
      cyc(0, 0, 0, 0, "R2 idle cycle");
      if (i % 3 == 0) cyc(0, 0, 0, 0, "R2 idle cycle");
    end

    // R1: spare select leaves the running ramp untouched
    for (int i = 0; i < 10; i++) begin
      cyc(0, 1, 3, 8'hFF, "R1 spare select ignored");
      cyc(1, 0, 0, 0, "R1 ramp after spare write");
    end

    // R2 R1: period using the high bits (0x103)
    cyc(0, 1, 2, 8'h00, "R8 disable");
    setup(8'h07, 12'h103, "R1 config high period");
    run(260 * 14 + 20, "R2 long period");

    // R8: re-writing enable while running does not restart
    cyc(0, 1, 2, 8'h81, "R8 enable rewrite keeps phase");
    run(300, "R8 after enable rewrite");

    // R7: disabled output stays 0 under ticks
    cyc(0, 1, 2, 8'h01, "R7 mute");
    run(20, "R7 muted ticks");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule